// File: doc/BRIEF.md
# NMI Aggregator with Escalation Watchdog

This block gathers five hardware error indications into sticky per-source flags and raises a non-maskable interrupt toward a local CPU. Each source flag can also be set from software for debug and cleared by writing a mask. The flags feed a latched summary bit. Each time the summary bit turns on, the block sends a one-cycle NMI pulse.

While the summary bit is set, a 16-bit watchdog counts system clock cycles. Software acknowledges the interrupt by clearing the summary bit. This is the only acknowledge, and it stops the watchdog and returns it to zero. If the count reaches the programmed period first, the block emits a one-cycle reset request for the subsystem. It also emits a one-cycle notification toward a supervising subsystem.

Software reaches the block through a simple register port. The port has a single-cycle write strobe with an address and data, and a combinational read path that follows the address.

Top module: `nmi_escalator`

## Requirements
- R1: After synchronous reset all source flags and the summary bit are 0, the watchdog count is 0, the period reads 0xFFFF, and nmi_o, rst_req_o and notify_o are low.
- R2: Register map on addr_i. Address 0 reads the status word: bit 0 RAM uncorrectable, bit 1 clock failure, bit 2 flash uncorrectable, bit 3 inter-processor bus error, bit 4 external event, bit 15 summary. Address 1 is the write-1-to-clear mask, using the same bit positions. Address 2 is the write-1-to-set force mask for bits 4:0. Address 3 is the period (read/write). Address 4 is the watchdog count (read only). Addresses 1, 2 and 5 to 7 read as 0.
- R3: An error input that is high at a clock edge sets its flag at that edge. The flag stays set after the input drops.
- R4: Writing 1 to a force bit sets that flag, and writing 1 to a clear bit clears it. Mask bits written as 0 leave their flags unchanged.
- R5: If an error event or force and a clear hit the same flag at the same edge, the flag ends up set.
- R6: The summary bit becomes 1 at the edge after any source flag is 1. It stays 1 until bit 15 is written through the clear mask, even if all source flags are cleared.
- R7: nmi_o is high for exactly one cycle: the cycle in which the summary bit has just turned from 0 to 1.
- R8: With the summary bit set at edge E, the count reads k after edge E+k, up to the period. The count then holds at the period while the summary bit stays set.
- R9: If the summary bit stays set, rst_req_o and notify_o are both high for exactly one cycle after edge E+P+1, where P is the period. They pulse only once per arming.
- R10: Writing clear bit 15 clears the summary bit and zeroes the count at that same edge. No timeout pulse follows from that arming.
- R11: If the summary bit is cleared while a source flag is still set, the summary bit sets again at the next edge. A new NMI pulse follows, and the watchdog restarts from 0.
- R12: A period of 0 produces the timeout pulse in the cycle right after the summary bit turns on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| err_i | input | 5 | Error event lines, one per source, in status-bit order |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| nmi_o | output | 1 | One-cycle NMI pulse to the local CPU |
| rst_req_o | output | 1 | One-cycle subsystem reset request on timeout |
| notify_o | output | 1 | One-cycle timeout notification to the supervisor |

## Verification
The bound checker watches the following on every cycle:
- error latching into flags;
- the summary bit following a set flag;
- nmi_o and the timeout outputs being single-cycle;
- the count stepping by one below the period;
- the acknowledge zeroing both summary and count.

Only the bench scenarios show the following:
- the exact cycle of each NMI and timeout pulse against a scoreboard of predicted events;
- set-over-clear priority on one flag;
- re-arming after an acknowledge that leaves a source set;
- the zero-period case;
- the register map, including reads of unused addresses.

// File: rtl/nmi_esc_pkg.sv
package nmi_esc_pkg;

    localparam int NUM_SRC = 5;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int SUM_BIT = DATA_W - 1;
    localparam logic [CNT_W-1:0] PRD_RST = '1;

    // Source bit order: 0 RAM uncorrectable, 1 clock failure,
    // 2 flash uncorrectable, 3 inter-processor bus error, 4 external event.
    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 3'd0,
        REG_CLR  = 3'd1,
        REG_FRC  = 3'd2,
        REG_PRD  = 3'd3,
        REG_CNT  = 3'd4
    } nmi_reg_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] frc;
        logic [NUM_SRC-1:0] clr;
        logic               sum_clr;
        logic               prd_we;
        logic [CNT_W-1:0]   prd_val;
    } nmi_wr_t;

    function automatic nmi_wr_t decode_wr(input logic we,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic [DATA_W-1:0] data);
        nmi_wr_t r;
        r = '0;
        if (we) begin
            case (addr)
                REG_CLR: begin
                    r.clr     = data[NUM_SRC-1:0];
                    r.sum_clr = data[SUM_BIT];
                end
                REG_FRC: r.frc = data[NUM_SRC-1:0];
                REG_PRD: begin
                    r.prd_we  = 1'b1;
                    r.prd_val = data[CNT_W-1:0];
                end
                default: ;
            endcase
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input logic [NUM_SRC-1:0] src,
                                                      input logic sum);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_SRC-1:0] = src;
        r[SUM_BIT]     = sum;
        return r;
    endfunction

endpackage

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] frc_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_q;
        // set dominates clear so that no event is dropped
        always_ff @(posedge clk_i) begin
            if (rst_i)                      bit_q <= 1'b0;
            else if (evt_i[g] || frc_i[g])  bit_q <= 1'b1;
            else if (clr_i[g])              bit_q <= 1'b0;
        end
        assign flag_o[g] = bit_q;
    end
endmodule

// File: rtl/nmi_summary.sv
module nmi_summary (
    input  logic clk_i,
    input  logic rst_i,
    input  logic any_i,
    input  logic ack_i,
    output logic sum_o,
    output logic nmi_o
);
    logic sum_q, nmi_q, sum_d;

    // acknowledge always wins for one edge; remaining sources re-arm next edge
    assign sum_d = ack_i ? 1'b0 : (sum_q | any_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sum_q <= 1'b0;
            nmi_q <= 1'b0;
        end else begin
            sum_q <= sum_d;
            nmi_q <= sum_d & ~sum_q;
        end
    end

    assign sum_o = sum_q;
    assign nmi_o = nmi_q;
endmodule

// File: rtl/nmi_watchdog.sv
module nmi_watchdog #(
    parameter int               W       = 16,
    parameter logic [W-1:0]     PRD_INI = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         armed_i,
    input  logic         stop_i,
    input  logic         prd_we_i,
    input  logic [W-1:0] prd_val_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] prd_o,
    output logic         tmo_o
);
    logic [W-1:0] prd_q, cnt_q;
    logic         fired_q, tmo_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)         prd_q <= PRD_INI;
        else if (prd_we_i) prd_q <= prd_val_i;
    end

    // greater-or-equal so a period lowered below the running count still expires
    always_ff @(posedge clk_i) begin
        if (rst_i || stop_i || !armed_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            tmo_q <= 1'b0;
            if (cnt_q >= prd_q) begin
                if (!fired_q) begin
                    tmo_q   <= 1'b1;
                    fired_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign prd_o = prd_q;
    assign tmo_o = tmo_q;
endmodule

// File: rtl/nmi_escalator.sv
module nmi_escalator
    import nmi_esc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_SRC-1:0]  err_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                nmi_o,
    output logic                rst_req_o,
    output logic                notify_o
);
    nmi_wr_t            wr;
    logic [NUM_SRC-1:0] src_flag;
    logic               sum_q;
    logic [CNT_W-1:0]   wd_cnt, wd_prd;
    logic               tmo;

    assign wr = decode_wr(wr_en_i, addr_i, wdata_i);

    nmi_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .evt_i (err_i),
        .frc_i (wr.frc),
        .clr_i (wr.clr),
        .flag_o(src_flag)
    );

    nmi_summary u_sum (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .any_i(|src_flag),
        .ack_i(wr.sum_clr),
        .sum_o(sum_q),
        .nmi_o(nmi_o)
    );

    nmi_watchdog #(.W(CNT_W), .PRD_INI(PRD_RST)) u_wd (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .armed_i  (sum_q),
        .stop_i   (wr.sum_clr),
        .prd_we_i (wr.prd_we),
        .prd_val_i(wr.prd_val),
        .cnt_o    (wd_cnt),
        .prd_o    (wd_prd),
        .tmo_o    (tmo)
    );

    assign rst_req_o = tmo;
    assign notify_o  = tmo;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_STAT: rdata_o = pack_status(src_flag, sum_q);
            REG_PRD:  rdata_o[CNT_W-1:0] = wd_prd;
            REG_CNT:  rdata_o[CNT_W-1:0] = wd_cnt;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/nmi_escalator_chk.sv
module nmi_escalator_chk
    import nmi_esc_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic [NUM_SRC-1:0] err_i,
    input logic [NUM_SRC-1:0] flags,
    input logic               sum,
    input logic               ack,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   prd,
    input logic               nmi_o,
    input logic               rst_req_o
);
    // R3
    err_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_i != '0) |=> ((flags & $past(err_i)) == $past(err_i)));

    // R6
    sum_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((|flags) && !ack) |=> sum);

    // R7
    nmi_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        nmi_o |=> !nmi_o);

    // R7
    nmi_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sum) |-> nmi_o);

    // R8
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sum && !ack && (cnt < prd)) |=> (cnt == $past(cnt) + 1'b1));

    // R10
    ack_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ack |=> (!sum && cnt == '0 && !rst_req_o));

    // R9
    tmo_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |=> !rst_req_o);

    // R9
    tmo_armed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_req_o |-> sum);
endmodule

bind nmi_escalator nmi_escalator_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .err_i    (err_i),
    .flags    (src_flag),
    .sum      (sum_q),
    .ack      (wr.sum_clr),
    .cnt      (wd_cnt),
    .prd      (wd_prd),
    .nmi_o    (nmi_o),
    .rst_req_o(rst_req_o)
);

// File: tb/sim_nmi_escalator.sv
module sim_nmi_escalator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  err_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        nmi_o, rst_req_o, notify_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int nmiq[$];
    int rstq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nmi_escalator u0 (
        .clk_i(clk), .rst_i(rst), .err_i(err_i), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .nmi_o(nmi_o), .rst_req_o(rst_req_o), .notify_o(notify_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, output int at);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        at = cyc;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // scoreboard monitor: every pulse must match a predicted cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rst_req_o !== notify_o) check("R9", "notify equals reset request", notify_o, rst_req_o);
            if (nmi_o) begin
                if (nmiq.size() == 0) check("R7", "unexpected NMI at cycle", cyc, 0);
                else check("R7", "NMI pulse cycle", cyc, nmiq.pop_front());
            end
            if (rst_req_o) begin
                if (rstq.size() == 0) check("R9", "unexpected timeout at cycle", cyc, 0);
                else check("R9", "timeout pulse cycle", cyc, rstq.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        int w, e, c;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); check("R1", "status after reset", d, 16'h0000);
        rd(3'd4, d); check("R1", "count after reset", d, 16'h0000);
        rd(3'd3, d); check("R1", "period after reset", d, 16'hFFFF);
        check("R1", "outputs after reset", {nmi_o, rst_req_o, notify_o}, 3'b000);

        // R2 period write/readback
        wr(3'd3, 16'd20, w);
        rd(3'd3, d); check("R2", "period readback", d, 16'd20);

        // R4 force clock-failure bit, R8 counting, R6 persistence, R10 ack
        wr(3'd2, 16'h0002, w);
        nmiq.push_back(w + 1);
        rd(3'd0, d); check("R4", "forced flag", d, 16'h0002);
        repeat (6) @(negedge clk);
        rd(3'd0, d); check("R6", "summary set", d, 16'h8002);
        rd(3'd4, d); check("R8", "count while armed", d, 16'(cyc - (w + 1)));
        wr(3'd1, 16'h0002, c);
        rd(3'd0, d); check("R6", "summary stays after source clear", d, 16'h8000);
        wr(3'd1, 16'h8000, c);
        rd(3'd0, d); check("R10", "status after ack", d, 16'h0000);
        rd(3'd4, d); check("R10", "count zero after ack", d, 16'h0000);
        repeat (30) @(negedge clk);
        rd(3'd4, d); check("R10", "count stays zero", d, 16'h0000);

        // R3 error input, R8 hold and R9 timeout
        @(negedge clk) err_i = 5'b00001;
        @(posedge clk);
        @(negedge clk);
        e = cyc; err_i = '0;
        nmiq.push_back(e + 1);
        rstq.push_back(e + 1 + 20 + 1);
        rd(3'd0, d); check("R3", "flag sticky after input drops", d, 16'h0001);
        repeat (35) @(negedge clk);
        rd(3'd4, d); check("R8", "count holds at period", d, 16'd20);
        rd(3'd0, d); check("R3", "flag and summary after timeout", d, 16'h8001);

        // R11 ack with a source still set
        wr(3'd1, 16'h8000, c);
        nmiq.push_back(c + 1);
        rd(3'd0, d); check("R11", "summary cleared for one cycle", d, 16'h0001);
        repeat (3) @(negedge clk);
        rd(3'd0, d); check("R11", "summary re-set", d, 16'h8001);
        rd(3'd4, d); check("R11", "count restarted", d, 16'(cyc - (c + 1)));
        wr(3'd1, 16'h801F, c);
        rd(3'd0, d); check("R10", "all clear", d, 16'h0000);

        // R5 set and clear on the same flag at once
        @(negedge clk);
        err_i = 5'b00100; wr_en = 1'b1; addr = 3'd1; wdata = 16'h0004;
        @(posedge clk);
        @(negedge clk);
        e = cyc; err_i = '0; wr_en = 1'b0; wdata = '0;
        nmiq.push_back(e + 1);
        rd(3'd0, d); check("R5", "set wins over clear", d, 16'h0004);
        wr(3'd1, 16'h801F, c);

        // R4 zero mask bits leave other flags alone
        wr(3'd2, 16'h0010, w);
        nmiq.push_back(w + 1);
        wr(3'd1, 16'h0001, c);
        rd(3'd0, d); check("R4", "unrelated clear bit no effect", d, 16'h8010);
        wr(3'd1, 16'h801F, c);
        rd(3'd0, d); check("R4", "clear all", d, 16'h0000);

        // R12 period zero
        wr(3'd3, 16'd0, w);
        wr(3'd2, 16'h0008, w);
        nmiq.push_back(w + 1);
        rstq.push_back(w + 2);
        repeat (6) @(negedge clk);
        rd(3'd4, d); check("R12", "count at zero period", d, 16'h0000);
        wr(3'd1, 16'h801F, c);

        // R2 write-only and unused addresses read zero
        rd(3'd1, d); check("R2", "clear mask reads zero", d, 16'h0000);
        rd(3'd2, d); check("R2", "force mask reads zero", d, 16'h0000);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d); check("R2", "unused address reads zero", d, 16'h0000);
        end

        repeat (5) @(negedge clk);
        check("R7", "no NMI left pending", nmiq.size(), 0);
        check("R9", "no timeout left pending", rstq.size(), 0);
        finish_run();
    end
endmodule